// File: doc/BRIEF.md
# Triggered command set sequencer

The sequencer owns a small bank of command sets. Each set has a fixed number of command slots, and each slot holds a message-id word, a target address and a data word. A host programs the slots through a flat register window. For each set it also programs a command-enable mask, which selects the slots that take part, and a wait-for-completion mask, which selects the slots whose completion must be seen before the sequencer moves on.

A set starts through a two-bit control handshake. Active-mode enable is armed first, and trigger is set afterwards. The started set then sends its enabled commands in ascending slot order to a downstream resource manager over a request/acknowledge bus. Only one request is outstanding at a time. When several sets are pending, the lowest-numbered set runs first and runs to its end. The sequencer records, for every slot, whether the command went out and whether its completion came back. At the end of a set it raises a per-set done flag, gated by an interrupt enable, which the host clears by writing a one.

Top module: `css_seq`

## Requirements
- R1: Set `s` starts at byte address `672*s`. Its slot `k` starts at `672*s + 0x30 + 20*k`. Per-set words: wait mask +0x10, control +0x14, idle +0x18, command enable +0x1C. Per-slot words: message id +0, address +4, data +8, status +12. Each programmable word reads back the value last written.
- R2: The interrupt enable (+0x00), done status (+0x04) and done clear (+0x08) words exist only at set 0's base, with bit `s` belonging to set `s`.
- R3: Control bit 16 is the active-mode enable and bit 24 is the trigger. A set starts only on a control write that sets both bits when, before that write, enable was 1, trigger was 0 and the set was idle. Setting both bits at once from zero starts nothing.
- R4: A started set issues only the slots whose command-enable bit is 1, in ascending slot order, on `req_addr`/`req_data`/`req_msgid`. `req_valid` and the request fields hold until `req_ack`.
- R5: When a slot's wait-mask bit is 1, no further request is made until `cmp_valid` arrives. When the bit is 0, the next request follows the acknowledge directly.
- R6: Slot status bit 8 (issued) is set by the acknowledge. Bit 16 (completed) is set by the completion of a waited slot. Starting a set clears the status of all its slots.
- R7: The idle word reads 1 while the set is not running and 0 from its start until its last enabled command finishes.
- R8: When a set finishes, its done status bit is set only if its interrupt enable bit is 1. `irq` is the OR of all done status bits.
- R9: Writing the clear word clears the done bits where the written value has a one and leaves the bits where it has a zero.
- R10: When several sets are pending, the lowest-numbered one is served next, and a set runs to its end before another begins.
- R11: A set started with an all-zero command-enable mask finishes without making any request.
- R12: The message-id word of a slot is passed unchanged on `req_msgid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host byte address |
| reg_wdata | input | WORD_W | Host write data |
| reg_rdata | output | WORD_W | Host read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Command request pending |
| req_msgid | output | WORD_W | Message-id word of the current slot |
| req_addr | output | WORD_W | Target address of the current slot |
| req_data | output | WORD_W | Data word of the current slot |
| req_ack | input | 1 | Downstream accepts the current request |
| cmp_valid | input | 1 | Completion for the waited request |
| irq | output | 1 | OR of the done status bits |

## Verification
Set 0 is run under all sixteen command-enable masks. Each mask is paired with a rotated wait mask, so that every mix of enabled, skipped, waited and unwaited slots occurs. This separates errors in slot selection, in ordering, and in the issued and completed status bits. The done bit is checked with the interrupt enable both on and off, and the clear word is written first with zeros and then with a one. A start in which both control bits are set in one write must do nothing, while the ordered handshake must run the set. Finally, three sets are left pending at the same time, and the sequence of addresses shows both the lowest-index-first choice and that each set runs to its end.

// File: rtl/css_pkg.sv
// Package for the command set sequencer.
// Holds the register map constants, the control and status bit positions,
// the decoded register kinds and the engine states.
// Assumes 32-bit host and command words.
package css_pkg;
    localparam int WORD_W = 32;

    localparam int unsigned SET_STRIDE = 672;
    localparam int unsigned CMD_BASE   = 32'h30;
    localparam int unsigned CMD_STRIDE = 20;

    localparam int unsigned OFF_IRQ_EN  = 32'h00;
    localparam int unsigned OFF_IRQ_ST  = 32'h04;
    localparam int unsigned OFF_IRQ_CLR = 32'h08;
    localparam int unsigned OFF_WAIT    = 32'h10;
    localparam int unsigned OFF_CTRL    = 32'h14;
    localparam int unsigned OFF_IDLE    = 32'h18;
    localparam int unsigned OFF_CMD_EN  = 32'h1C;

    localparam int unsigned FLD_MSG  = 0;
    localparam int unsigned FLD_ADDR = 4;
    localparam int unsigned FLD_DATA = 8;
    localparam int unsigned FLD_STAT = 12;

    localparam int CTRL_EN_BIT   = 16;
    localparam int CTRL_TRIG_BIT = 24;
    localparam int STAT_ISS_BIT  = 8;
    localparam int STAT_CMP_BIT  = 16;

    typedef enum logic [3:0] {
        RK_NONE, RK_IRQ_EN, RK_IRQ_ST, RK_IRQ_CLR, RK_WAIT, RK_CTRL,
        RK_IDLE, RK_CMD_EN, RK_MSG, RK_CADDR, RK_CDATA, RK_CSTAT
    } reg_kind_e;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} eng_st_e;
endpackage

// File: rtl/css_reg_decode.sv
// Host address decoder.
// Splits a byte address into a set index, a slot index and a register kind.
// Assumes word-aligned accesses; unmapped addresses decode to RK_NONE.
module css_reg_decode
    import css_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_SETS = 3,
    parameter int SLOTS    = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SET_W-1:0]  set_idx,
    output logic [SLOT_W-1:0] slot_idx
);
    logic [31:0] set_n, off, rel, slot_n, field;

    // Divide the address by the strides and name the word it hits.
    always_comb begin
        set_n  = 32'(addr) / SET_STRIDE;
        off    = 32'(addr) % SET_STRIDE;
        rel    = off - CMD_BASE;
        slot_n = rel / CMD_STRIDE;
        field  = rel % CMD_STRIDE;
        kind   = RK_NONE;
        if (set_n < 32'(NUM_SETS)) begin
            if (off >= CMD_BASE) begin
                if (slot_n < 32'(SLOTS)) begin
                    case (field)
                        FLD_MSG:  kind = RK_MSG;
                        FLD_ADDR: kind = RK_CADDR;
                        FLD_DATA: kind = RK_CDATA;
                        FLD_STAT: kind = RK_CSTAT;
                        default:  kind = RK_NONE;
                    endcase
                end
            end else begin
                case (off)
                    OFF_IRQ_EN:  kind = (set_n == 0) ? RK_IRQ_EN  : RK_NONE;
                    OFF_IRQ_ST:  kind = (set_n == 0) ? RK_IRQ_ST  : RK_NONE;
                    OFF_IRQ_CLR: kind = (set_n == 0) ? RK_IRQ_CLR : RK_NONE;
                    OFF_WAIT:    kind = RK_WAIT;
                    OFF_CTRL:    kind = RK_CTRL;
                    OFF_IDLE:    kind = RK_IDLE;
                    OFF_CMD_EN:  kind = RK_CMD_EN;
                    default:     kind = RK_NONE;
                endcase
            end
        end
        set_idx  = set_n[SET_W-1:0];
        slot_idx = slot_n[SLOT_W-1:0];
    end
endmodule

// File: rtl/css_lowest_pick.sv
// Lowest-set-bit picker.
// Reports whether any bit of vec is set and the index of the lowest one.
// Used both for the set priority and for the slot order.
module css_lowest_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so that the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/css_seq.sv
// Triggered command set sequencer, top level.
// Holds the slot storage and the per-set masks, control, busy and done
// state, and runs one shared engine that issues one command at a time.
// Assumes the responder sends cmp_valid only for waited commands, after
// their acknowledge.
module css_seq
    import css_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_SETS = 3,
    parameter int SLOTS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              req_valid,
    output logic [WORD_W-1:0] req_msgid,
    output logic [WORD_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_data,
    input  logic              req_ack,
    input  logic              cmp_valid,
    output logic              irq
);
    localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [WORD_W-1:0] msg_q  [NUM_SETS][SLOTS];
    logic [WORD_W-1:0] addr_q [NUM_SETS][SLOTS];
    logic [WORD_W-1:0] data_q [NUM_SETS][SLOTS];
    logic [SLOTS-1:0]  en_q   [NUM_SETS];
    logic [SLOTS-1:0]  wait_q [NUM_SETS];
    logic [SLOTS-1:0]  iss_q  [NUM_SETS];
    logic [SLOTS-1:0]  cmpl_q [NUM_SETS];
    logic [NUM_SETS-1:0] ctl_en_q, ctl_trig_q, busy_q, irq_en_q, irq_st_q;

    reg_kind_e         dk;
    logic [SET_W-1:0]  ds;
    logic [SLOT_W-1:0] dl;

    eng_st_e           st_q;
    logic [SET_W-1:0]  cur_set;
    logic [SLOT_W-1:0] cur_slot;

    logic              arb_found, first_found, nxt_found;
    logic [SET_W-1:0]  arb_idx;
    logic [SLOT_W-1:0] first_idx, nxt_idx;
    logic [SLOTS-1:0]  above_mask;
    logic [NUM_SETS-1:0] start_vec, fin_vec, clr_vec;
    logic iss_ev, cmp_ev, adv, fin_ev, cur_wait;
    logic [SET_W-1:0]  fin_set;

    css_reg_decode #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .SLOTS(SLOTS)) u_dec (
        .addr(reg_addr), .kind(dk), .set_idx(ds), .slot_idx(dl)
    );

    css_lowest_pick #(.N(NUM_SETS), .IDX_W(SET_W)) u_arb (
        .vec(busy_q), .found(arb_found), .idx(arb_idx)
    );

    css_lowest_pick #(.N(SLOTS), .IDX_W(SLOT_W)) u_first (
        .vec(en_q[arb_idx]), .found(first_found), .idx(first_idx)
    );

    css_lowest_pick #(.N(SLOTS), .IDX_W(SLOT_W)) u_next (
        .vec(above_mask), .found(nxt_found), .idx(nxt_idx)
    );

    // Engine events, start detection and done/clear vectors.
    always_comb begin
        above_mask = en_q[cur_set] & ~((SLOTS'(2) << cur_slot) - SLOTS'(1));
        cur_wait   = wait_q[cur_set][cur_slot];
        iss_ev     = (st_q == ST_ISSUE) && req_ack;
        cmp_ev     = (st_q == ST_WAIT) && cmp_valid;
        adv        = (iss_ev && !cur_wait) || cmp_ev;
        fin_ev     = ((st_q == ST_IDLE) && arb_found && !first_found) || (adv && !nxt_found);
        fin_set    = (st_q == ST_IDLE) ? arb_idx : cur_set;
        fin_vec    = fin_ev ? (NUM_SETS'(1) << fin_set) : '0;
        clr_vec    = (reg_wr && dk == RK_IRQ_CLR) ? reg_wdata[NUM_SETS-1:0] : '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            start_vec[s] = reg_wr && (dk == RK_CTRL) && (ds == SET_W'(s))
                         && reg_wdata[CTRL_TRIG_BIT] && reg_wdata[CTRL_EN_BIT]
                         && ctl_en_q[s] && !ctl_trig_q[s] && !busy_q[s];
        end
    end

    // Engine state: pick a set, walk its enabled slots, wait where asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_set  <= '0;
            cur_slot <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (arb_found && first_found) begin
                    cur_set  <= arb_idx;
                    cur_slot <= first_idx;
                    st_q     <= ST_ISSUE;
                end
                ST_ISSUE: if (req_ack) begin
                    if (cur_wait) st_q <= ST_WAIT;
                    else if (nxt_found) cur_slot <= nxt_idx;
                    else st_q <= ST_IDLE;
                end
                ST_WAIT: if (cmp_valid) begin
                    if (nxt_found) begin
                        cur_slot <= nxt_idx;
                        st_q     <= ST_ISSUE;
                    end else st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Busy flags and done status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= '0;
            irq_st_q <= '0;
        end else begin
            busy_q   <= (busy_q | start_vec) & ~fin_vec;
            irq_st_q <= (irq_st_q & ~clr_vec) | (fin_vec & irq_en_q);
        end
    end

    // Host-programmed configuration: masks, control bits and slot words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q   <= '0;
            ctl_en_q   <= '0;
            ctl_trig_q <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
                en_q[s]   <= '0;
                wait_q[s] <= '0;
                for (int k = 0; k < SLOTS; k++) begin
                    msg_q[s][k]  <= '0;
                    addr_q[s][k] <= '0;
                    data_q[s][k] <= '0;
                end
            end
        end else if (reg_wr) begin
            case (dk)
                RK_IRQ_EN: irq_en_q <= reg_wdata[NUM_SETS-1:0];
                RK_WAIT:   wait_q[ds] <= reg_wdata[SLOTS-1:0];
                RK_CMD_EN: en_q[ds] <= reg_wdata[SLOTS-1:0];
                RK_CTRL: begin
                    ctl_en_q[ds]   <= reg_wdata[CTRL_EN_BIT];
                    ctl_trig_q[ds] <= reg_wdata[CTRL_TRIG_BIT];
                end
                RK_MSG:   msg_q[ds][dl]  <= reg_wdata;
                RK_CADDR: addr_q[ds][dl] <= reg_wdata;
                RK_CDATA: data_q[ds][dl] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Per-slot issued and completed status, cleared when the set starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                iss_q[s]  <= '0;
                cmpl_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NUM_SETS; s++) begin
                if (start_vec[s]) begin
                    iss_q[s]  <= '0;
                    cmpl_q[s] <= '0;
                end
            end
            if (iss_ev) iss_q[cur_set][cur_slot] <= 1'b1;
            if (cmp_ev) cmpl_q[cur_set][cur_slot] <= 1'b1;
        end
    end

    // Host read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (dk)
            RK_IRQ_EN: reg_rdata = WORD_W'(irq_en_q);
            RK_IRQ_ST: reg_rdata = WORD_W'(irq_st_q);
            RK_WAIT:   reg_rdata = WORD_W'(wait_q[ds]);
            RK_CMD_EN: reg_rdata = WORD_W'(en_q[ds]);
            RK_IDLE:   reg_rdata = WORD_W'(!busy_q[ds]);
            RK_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = ctl_en_q[ds];
                reg_rdata[CTRL_TRIG_BIT] = ctl_trig_q[ds];
            end
            RK_MSG:   reg_rdata = msg_q[ds][dl];
            RK_CADDR: reg_rdata = addr_q[ds][dl];
            RK_CDATA: reg_rdata = data_q[ds][dl];
            RK_CSTAT: begin
                reg_rdata[STAT_ISS_BIT] = iss_q[ds][dl];
                reg_rdata[STAT_CMP_BIT] = cmpl_q[ds][dl];
            end
            default: reg_rdata = '0;
        endcase
    end

    // Outputs toward the resource manager.
    always_comb begin
        req_valid = (st_q == ST_ISSUE);
        req_msgid = msg_q[cur_set][cur_slot];
        req_addr  = addr_q[cur_set][cur_slot];
        req_data  = data_q[cur_set][cur_slot];
        irq       = |irq_st_q;
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_data) && $stable(req_msgid)));

    // R5
    wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack && wait_q[cur_set][cur_slot]) |=> !req_valid);

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set_chk
            // R8
            irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_st_q[s]) |-> $past(irq_en_q[s]));
            for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
                // R6
                cmpl_after_iss_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    cmpl_q[s][k] |-> iss_q[s][k]);
            end
        end
    endgenerate
endmodule

// File: tb/test_css_seq.sv
module test_css_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [31:0] req_msgid, req_addr, req_data;
    logic        req_ack = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int ack_lat = 1;
    int cmp_lat = 2;
    int log_n = 0;
    bit early = 1'b0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [31:0] log_msg  [64];

    css_seq i_css_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_msgid(req_msgid), .req_addr(req_addr), .req_data(req_data),
        .req_ack(req_ack), .cmp_valid(cmp_valid), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [11:0] aset(int s, int off);
        return 12'(s * 672 + off);
    endfunction

    function automatic logic [11:0] acmd(int s, int k, int f);
        return 12'(s * 672 + 48 + k * 20 + f);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic trig(int s);
        wr(aset(s, 'h14), 32'h0001_0000);
        wr(aset(s, 'h14), 32'h0000_0000);
        wr(aset(s, 'h14), 32'h0001_0000);
        wr(aset(s, 'h14), 32'h0101_0000);
    endtask

    task automatic wait_idle(int s);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(aset(s, 'h18), v);
            if (v != 0) break;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Downstream responder: acknowledge after ack_lat cycles; complete
    // requests whose message id asks for a response after cmp_lat cycles.
    initial begin
        logic [31:0] a, d, m;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                a = req_addr; d = req_data; m = req_msgid;
                repeat (ack_lat) @(negedge clk);
                req_ack = 1'b1;
                @(negedge clk);
                req_ack = 1'b0;
                log_addr[log_n] = a; log_data[log_n] = d; log_msg[log_n] = m;
                log_n++;
                if (m[8]) begin
                    repeat (cmp_lat) begin
                        if (req_valid) early = 1'b1;
                        @(negedge clk);
                    end
                    if (req_valid) early = 1'b1;
                    cmp_valid = 1'b1;
                    @(negedge clk);
                    cmp_valid = 1'b0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        for (int s = 0; s < 3; s++) begin
            rd(aset(s, 'h18), v); chk("R7 reset idle", v, 1);
            rd(aset(s, 'h14), v); chk("R3 reset control", v, 0);
        end
        chk("R8 reset irq", {31'b0, irq}, 0);
        chk("R4 reset req_valid", {31'b0, req_valid}, 0);

        // R1 register readback across sets and slots
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                wr(acmd(s, k, 4), 32'h100 * (s + 1) + k);
                wr(acmd(s, k, 8), 32'hD000 + 16 * s + k);
            end
        end
        rd(acmd(2, 3, 4), v); chk("R1 slot addr readback", v, 32'h303);
        rd(acmd(1, 2, 8), v); chk("R1 slot data readback", v, 32'hD012);
        wr(aset(2, 'h10), 32'h9); rd(aset(2, 'h10), v); chk("R1 wait mask readback", v, 32'h9);
        wr(aset(1, 'h1C), 32'h6); rd(aset(1, 'h1C), v); chk("R1 enable readback", v, 32'h6);
        wr(acmd(0, 1, 0), 32'h10108); rd(acmd(0, 1, 0), v); chk("R1 msgid readback", v, 32'h10108);
        wr(aset(0, 'h00), 32'h5); rd(aset(0, 'h00), v); chk("R2 irq enable readback", v, 32'h5);

        // R3: both control bits at once from zero must not start set 1
        wr(aset(1, 'h1C), 32'h1);
        wr(acmd(1, 0, 0), 32'h10008);
        log_n = 0;
        wr(aset(1, 'h14), 32'h0101_0000);
        repeat (10) @(negedge clk);
        chk("R3 no start count", log_n, 0);
        rd(aset(1, 'h18), v); chk("R3 no start idle", v, 1);
        trig(1);
        wait_idle(1);
        chk("R3 ordered start runs", log_n, 1);
        rd(aset(1, 'h14), v); chk("R3 control readback", v, 32'h0101_0000);

        // Sweep all enable masks on set 0
        for (int m = 0; m < 16; m++) begin
            logic [3:0] em, wm;
            int idx;
            em = 4'(m);
            wm = 4'((((m << 1) | (m >> 3)) & 15) ^ 10);
            for (int k = 0; k < 4; k++)
                wr(acmd(0, k, 0), 32'h10008 | (wm[k] ? 32'h100 : 32'h0));
            wr(aset(0, 'h10), 32'(wm));
            wr(aset(0, 'h1C), 32'(em));
            wr(aset(0, 'h00), (m % 2 == 0) ? 32'h1 : 32'h0);
            log_n = 0; early = 1'b0;
            trig(0);
            if (m != 0) begin
                rd(aset(0, 'h18), v); chk("R7 busy after start", v, 0);
            end
            wait_idle(0);
            repeat (2) @(negedge clk);
            chk("R4 R11 request count", log_n, $countones(em));
            idx = 0;
            for (int k = 0; k < 4; k++) begin
                if (em[k]) begin
                    chk("R4 order addr", log_addr[idx], 32'h100 + k);
                    chk("R4 order data", log_data[idx], 32'hD000 + k);
                    chk("R12 msgid passthrough", log_msg[idx],
                        32'h10008 | (wm[k] ? 32'h100 : 32'h0));
                    idx++;
                end
                rd(acmd(0, k, 12), v);
                chk("R6 slot status", v, (em[k] ? 32'h100 : 32'h0)
                                       | ((em[k] && wm[k]) ? 32'h10000 : 32'h0));
            end
            chk("R5 no request during wait", {31'b0, early}, 0);
            rd(aset(0, 'h18), v); chk("R7 idle after finish", v, 1);
            rd(aset(0, 'h04), v);
            chk("R8 done status", v & 32'h1, (m % 2 == 0) ? 32'h1 : 32'h0);
            chk("R8 irq pin", {31'b0, irq}, (m % 2 == 0) ? 32'h1 : 32'h0);
            wr(aset(0, 'h08), 32'h0);
            rd(aset(0, 'h04), v);
            chk("R9 zero clear keeps", v & 32'h1, (m % 2 == 0) ? 32'h1 : 32'h0);
            wr(aset(0, 'h08), 32'h1);
            rd(aset(0, 'h04), v); chk("R9 one clears", v, 0);
            if (m == 0) chk("R11 empty mask no request", log_n, 0);
        end

        // R10: three pending sets, lowest index served first
        ack_lat = 3;
        cmp_lat = 3;
        for (int k = 0; k < 4; k++) wr(acmd(2, k, 0), 32'h10108);
        wr(aset(2, 'h10), 32'hF); wr(aset(2, 'h1C), 32'hF);
        for (int k = 0; k < 2; k++) wr(acmd(0, k, 0), 32'h10008);
        wr(aset(0, 'h10), 32'h0); wr(aset(0, 'h1C), 32'h3);
        wr(acmd(1, 2, 0), 32'h10008);
        wr(aset(1, 'h10), 32'h0); wr(aset(1, 'h1C), 32'h4);
        wr(aset(0, 'h00), 32'h7);
        log_n = 0;
        trig(2);
        trig(1);
        trig(0);
        wait_idle(2); wait_idle(0); wait_idle(1);
        repeat (4) @(negedge clk);
        chk("R10 total requests", log_n, 7);
        chk("R10 order 0", log_addr[0], 32'h300);
        chk("R10 order 3", log_addr[3], 32'h303);
        chk("R10 order 4", log_addr[4], 32'h100);
        chk("R10 order 5", log_addr[5], 32'h101);
        chk("R10 order 6", log_addr[6], 32'h202);
        rd(aset(0, 'h04), v); chk("R8 all done bits", v, 32'h7);
        wr(aset(0, 'h08), 32'h5);
        rd(aset(0, 'h04), v); chk("R9 partial clear", v, 32'h2);

        summary();
    end
endmodule